// File: doc/BRIEF.md
# Fractional SPI Serial Clock Profile Generator

This block generates the serial clock for an SPI master from a fast reference clock, and tells the shift datapath when to drive and when to sample data. Each of several clock profiles holds an increment for an 11-bit phase accumulator. The accumulator wraps at 2048, and every wrap flips the serial clock phase. The SCK rate is therefore a fraction of the reference rate rather than an integer divide of it. A profile can also clear the accumulator on every wrap, so that each half period has the same length.

The idle polarity is a global setting. Each profile chooses separately whether output data is launched on the rising or on the falling SCK edge, and whether input data is latched on the rising or on the falling edge. The block emits a one-cycle launch strobe and a one-cycle latch strobe at the matching edges, and captures the serial input bit at each latch edge. The capture uses either the raw pin or a copy registered one reference cycle earlier.

A command start selects the profile and restarts the phase, so the first edge lands at a known distance from the start. A global gate option holds the clock idle while no slave select is active.

Top module: `spi_sck_profile_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sck equals cpol, launchStb and latchStb are 0, and sampleBit is 0.
- R2: Let incr be the 12-bit increment of the active profile. The SCK phase flips on each stepping reference cycle in which accumulator plus incr is 2048 or more. An incr of 0 never flips the phase, and an incr of 2048 or more flips it on every stepping cycle.
- R3: With the profile's wrap-clear bit at 0, the accumulator keeps the remainder at each wrap. After N stepping cycles from a cleared state, the number of phase flips is floor(N*incr/2048) (for incr below 2048).
- R4: With the profile's wrap-clear bit at 1, the accumulator returns to 0 at each wrap. Phase flips are then spaced exactly ceil(2048/incr) reference cycles apart.
- R5: A cycle with cmdStart high latches profSel as the active profile and clears both the accumulator and the phase, with no strobe in that cycle. The first flip follows ceil(2048/incr) cycles later.
- R6: sck equals cpol while the phase is inactive and the inverse of cpol while it is active. A flip to the active phase is the leading edge, and a flip back is the trailing edge.
- R7: launchStb is high for one cycle at each flip where the new sck level equals the profile's launch bit (1 = rising, 0 = falling). latchStb does the same using the profile's latch bit. Both strobes are produced only when ssActive was high at that edge.
- R8: With gateOff at 1 and ssActive at 0, the accumulator and the phase are held cleared and sck stays at cpol. With gateOff at 0, the clock keeps running without ssActive, but no strobes are produced.
- R9: At a latch edge, sampleBit captures misoIn directly if the profile's async bit is 1, and otherwise the value misoIn had one reference cycle earlier. sampleBit holds its value between latch edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpol | input | 1 | Global SCK idle level |
| gateOff | input | 1 | Hold SCK idle while no slave select is active |
| ssActive | input | 1 | A slave select is asserted |
| cmdStart | input | 1 | Start pulse: latch the profile and restart the phase |
| profSel | input | PROF_W | Profile chosen at start |
| profIncr | input | NUM_PROF*INC_W | Increment per profile, profile 0 in the low bits |
| profLoopRst | input | NUM_PROF | Clear the accumulator at each wrap, per profile |
| profLaunchRise | input | NUM_PROF | Launch on the rising edge (1) or the falling edge (0) |
| profLatchRise | input | NUM_PROF | Latch on the rising edge (1) or the falling edge (0) |
| profAsyncIn | input | NUM_PROF | Sample the raw input pin instead of the registered copy |
| misoIn | input | 1 | Serial input data |
| sck | output | 1 | Serial clock |
| launchStb | output | 1 | One-cycle strobe at the launch edge |
| latchStb | output | 1 | One-cycle strobe at the latch edge |
| sampleBit | output | 1 | Input bit captured at the last latch edge |

## Verification
The bench uses the default parameters: four profiles, an 11-bit accumulator and a 12-bit increment. These values allow increments from 0 up to 4095, so both extremes of R2 can be driven: a stalled clock, and a flip on every reference cycle. Each table vector is bound to a different profile slot while the other slots carry decoy values, so a fault in profile selection changes the counted edges. The window of 41 cycles is chosen so that the remainder-keeping and the wrap-clearing behaviour give different edge counts for the same increment.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic clear;     // clear accumulator and phase
    logic step;      // advance the accumulator
    logic strobeEn;  // edges may produce strobes
  } sck_ctrl_t;
endpackage

// File: rtl/spi_sck_ctrl.sv
module spi_sck_ctrl
  import spi_sck_pkg::*;
#(
  parameter int NUM_PROF = 4,
  parameter int INC_W    = 12,
  parameter int PROF_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdStart,
  input  logic [PROF_W-1:0]         profSel,
  input  logic                      ssActive,
  input  logic                      gateOff,
  input  logic [NUM_PROF*INC_W-1:0] profIncr,
  input  logic [NUM_PROF-1:0]       profLoopRst,
  input  logic [NUM_PROF-1:0]       profLaunchRise,
  input  logic [NUM_PROF-1:0]       profLatchRise,
  input  logic [NUM_PROF-1:0]       profAsyncIn,
  output sck_ctrl_t                 ctrl,
  output logic [INC_W-1:0]          curIncr,
  output logic                      curLoopRst,
  output logic                      curLaunchRise,
  output logic                      curLatchRise,
  output logic                      curAsyncIn
);
  logic [INC_W-1:0]  incrArr [NUM_PROF];
  logic [PROF_W-1:0] activeProf;

  for (genvar g = 0; g < NUM_PROF; g++) begin : g_slice
    assign incrArr[g] = profIncr[g*INC_W +: INC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         activeProf <= '0;
    else if (cmdStart) activeProf <= profSel;
  end

  assign curIncr       = incrArr[activeProf];
  assign curLoopRst    = profLoopRst[activeProf];
  assign curLaunchRise = profLaunchRise[activeProf];
  assign curLatchRise  = profLatchRise[activeProf];
  assign curAsyncIn    = profAsyncIn[activeProf];

  logic holdIdle;
  assign holdIdle      = gateOff && !ssActive;
  assign ctrl.clear    = cmdStart || holdIdle;
  assign ctrl.step     = !(cmdStart || holdIdle);
  assign ctrl.strobeEn = ssActive;
endmodule

// File: rtl/spi_sck_dp.sv
module spi_sck_dp
  import spi_sck_pkg::*;
#(
  parameter int ACC_W = 11,
  parameter int INC_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  sck_ctrl_t        ctrl,
  input  logic [INC_W-1:0] incr,
  input  logic             loopRst,
  input  logic             launchRise,
  input  logic             latchRise,
  input  logic             asyncIn,
  input  logic             cpol,
  input  logic             misoIn,
  output logic             sck,
  output logic             launchStb,
  output logic             latchStb,
  output logic             sampleBit
);
  localparam int SUM_W = INC_W + 1;
  localparam logic [SUM_W-1:0] WRAP_V = SUM_W'(1) << ACC_W;

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum;
  logic             wrap, phase, newSck, edgeOk, misoQ;

  assign sum    = {{(SUM_W-ACC_W){1'b0}}, acc} + {1'b0, incr};
  assign wrap   = ctrl.step && (sum >= WRAP_V);
  assign newSck = cpol ^ ~phase;
  assign edgeOk = wrap && ctrl.strobeEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      phase <= 1'b0;
    end else if (ctrl.clear) begin
      acc   <= '0;
      phase <= 1'b0;
    end else begin
      acc <= (wrap && loopRst) ? '0 : sum[ACC_W-1:0];
      if (wrap) phase <= ~phase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      launchStb <= 1'b0;
      latchStb  <= 1'b0;
      misoQ     <= 1'b0;
      sampleBit <= 1'b0;
    end else begin
      launchStb <= edgeOk && (newSck == launchRise);
      latchStb  <= edgeOk && (newSck == latchRise);
      misoQ     <= misoIn;
      if (edgeOk && (newSck == latchRise))
        sampleBit <= asyncIn ? misoIn : misoQ;
    end
  end

  assign sck = cpol ^ phase;
endmodule

// File: rtl/spi_sck_profile_gen.sv
module spi_sck_profile_gen
  import spi_sck_pkg::*;
#(
  parameter int NUM_PROF = 4,
  parameter int ACC_W    = 11,
  parameter int INC_W    = 12,
  localparam int PROF_W  = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpol,
  input  logic                      gateOff,
  input  logic                      ssActive,
  input  logic                      cmdStart,
  input  logic [PROF_W-1:0]         profSel,
  input  logic [NUM_PROF*INC_W-1:0] profIncr,
  input  logic [NUM_PROF-1:0]       profLoopRst,
  input  logic [NUM_PROF-1:0]       profLaunchRise,
  input  logic [NUM_PROF-1:0]       profLatchRise,
  input  logic [NUM_PROF-1:0]       profAsyncIn,
  input  logic                      misoIn,
  output logic                      sck,
  output logic                      launchStb,
  output logic                      latchStb,
  output logic                      sampleBit
);
  sck_ctrl_t        ctrl;
  logic [INC_W-1:0] curIncr;
  logic             curLoopRst, curLaunchRise, curLatchRise, curAsyncIn;

  spi_sck_ctrl #(.NUM_PROF(NUM_PROF), .INC_W(INC_W), .PROF_W(PROF_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .profSel(profSel),
    .ssActive(ssActive), .gateOff(gateOff), .profIncr(profIncr),
    .profLoopRst(profLoopRst), .profLaunchRise(profLaunchRise),
    .profLatchRise(profLatchRise), .profAsyncIn(profAsyncIn),
    .ctrl(ctrl), .curIncr(curIncr), .curLoopRst(curLoopRst),
    .curLaunchRise(curLaunchRise), .curLatchRise(curLatchRise),
    .curAsyncIn(curAsyncIn)
  );

  spi_sck_dp #(.ACC_W(ACC_W), .INC_W(INC_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .incr(curIncr),
    .loopRst(curLoopRst), .launchRise(curLaunchRise),
    .latchRise(curLatchRise), .asyncIn(curAsyncIn), .cpol(cpol),
    .misoIn(misoIn), .sck(sck), .launchStb(launchStb),
    .latchStb(latchStb), .sampleBit(sampleBit)
  );
endmodule

// File: rtl/spi_sck_chk.sv
module spi_sck_chk
  import spi_sck_pkg::*;
#(
  parameter int ACC_W = 11,
  parameter int INC_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpol,
  input logic             gateOff,
  input logic             ssActive,
  input logic             cmdStart,
  input logic             sck,
  input logic             launchStb,
  input logic             latchStb,
  input sck_ctrl_t        ctrl,
  input logic [INC_W-1:0] curIncr,
  input logic             curLaunchRise,
  input logic             curLatchRise
);
  localparam int WRAP = 1 << ACC_W;
  logic pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  p_gate_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gateOff && !ssActive) |=> (sck == cpol));

  p_no_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ssActive |=> (!launchStb && !latchStb));

  p_start_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> (!launchStb && !latchStb && sck == cpol));

  p_launch_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && launchStb && $stable(cpol) && $stable(curLaunchRise))
      |-> (!$stable(sck) && sck == curLaunchRise));

  p_latch_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && latchStb && $stable(cpol) && $stable(curLatchRise))
      |-> (!$stable(sck) && sck == curLatchRise));

  p_full_incr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(ctrl.step) && (int'($past(curIncr)) >= WRAP) && $stable(cpol))
      |-> !$stable(sck));

  p_zero_incr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(ctrl.step) && ($past(curIncr) == '0) && $stable(cpol))
      |-> $stable(sck));
endmodule

bind spi_sck_profile_gen spi_sck_chk #(.ACC_W(ACC_W), .INC_W(INC_W)) chk_i (
  .clk(clk), .rstN(rstN), .cpol(cpol), .gateOff(gateOff),
  .ssActive(ssActive), .cmdStart(cmdStart), .sck(sck),
  .launchStb(launchStb), .latchStb(latchStb), .ctrl(ctrl),
  .curIncr(curIncr), .curLaunchRise(curLaunchRise),
  .curLatchRise(curLatchRise)
);

// File: tb/spi_sck_profile_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sck_profile_gen_tb_top;
  localparam int NP = 4;
  localparam int IW = 12;
  localparam int WIN = 41;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpol = 0, gateOff = 1, ssActive = 0, cmdStart = 0, misoIn = 0;
  logic [1:0] profSel = '0;
  logic [NP*IW-1:0] profIncr = '0;
  logic [NP-1:0] profLoopRst = '0, profLaunchRise = '0, profLatchRise = '0, profAsyncIn = '0;
  logic sck, launchStb, latchStb, sampleBit;

  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  spi_sck_profile_gen dut_i (
    .clk(clk), .rstN(rstN), .cpol(cpol), .gateOff(gateOff),
    .ssActive(ssActive), .cmdStart(cmdStart), .profSel(profSel),
    .profIncr(profIncr), .profLoopRst(profLoopRst),
    .profLaunchRise(profLaunchRise), .profLatchRise(profLatchRise),
    .profAsyncIn(profAsyncIn), .misoIn(misoIn), .sck(sck),
    .launchStb(launchStb), .latchStb(latchStb), .sampleBit(sampleBit)
  );

  typedef struct packed {
    logic [11:0] incr;
    logic        loopRst;
    logic        cp;
    logic        launchR;
    logic        latchR;
    logic [1:0]  prof;
    logic [7:0]  expTog;
    logic [7:0]  expFirst;   // 0 = no edge in window
  } vec_t;

  // Toggle counts over WIN cycles: R3 floor(N*incr/2048), R4 floor(N/ceil(2048/incr))
  localparam vec_t VECS [12] = '{
    '{12'd1024, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd20, 8'd2},
    '{12'd1024, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 8'd20, 8'd2},
    '{12'd700,  1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8'd14, 8'd3},
    '{12'd700,  1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 8'd13, 8'd3},
    '{12'd2048, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'd41, 8'd1},
    '{12'd4095, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 8'd41, 8'd1},
    '{12'd0,    1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8'd0,  8'd0},
    '{12'd1,    1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 8'd0,  8'd0},
    '{12'd300,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd6,  8'd7},
    '{12'd300,  1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 8'd5,  8'd7},
    '{12'd1500, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'd30, 8'd2},
    '{12'd1500, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 8'd20, 8'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // Decoy values in every slot, then the chosen slot gets its settings
  task automatic loadProf(input int p, input logic [11:0] inc, input logic lr,
                          input logic la, input logic lt, input logic as);
    for (int i = 0; i < NP; i++) begin
      profIncr[i*IW +: IW] = 12'd2048;
      profLoopRst[i] = 1'b0; profLaunchRise[i] = ~la;
      profLatchRise[i] = ~lt; profAsyncIn[i] = ~as;
    end
    profIncr[p*IW +: IW] = inc;
    profLoopRst[p] = lr; profLaunchRise[p] = la;
    profLatchRise[p] = lt; profAsyncIn[p] = as;
  endtask

  task automatic startCmd(input int p);
    @(negedge clk);
    ssActive = 1; cmdStart = 1; profSel = 2'(p);
    @(negedge clk);
    cmdStart = 0;
  endtask

  task automatic runVec(input vec_t v);
    int tog = 0, first = 0, nl = 0, nt = 0, rise, expL, expT;
    logic prev;
    @(negedge clk);
    ssActive = 0; gateOff = 1; cpol = v.cp;
    loadProf(int'(v.prof), v.incr, v.loopRst, v.launchR, v.latchR, 1'b0);
    startCmd(int'(v.prof));
    prev = sck;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (sck != prev) begin tog++; if (first == 0) first = k; end
      if (launchStb) nl++;
      if (latchStb) nt++;
      prev = sck;
    end
    rise = v.cp ? int'(v.expTog) / 2 : (int'(v.expTog) + 1) / 2;
    expL = v.launchR ? rise : int'(v.expTog) - rise;
    expT = v.latchR ? rise : int'(v.expTog) - rise;
    chk($sformatf("R2 R3 R4 toggles incr=%0d rst=%0d", v.incr, v.loopRst), tog, int'(v.expTog));
    chk($sformatf("R5 first edge incr=%0d", v.incr), first, int'(v.expFirst));
    chk($sformatf("R6 R7 launch count incr=%0d", v.incr), nl, expL);
    chk($sformatf("R6 R7 latch count incr=%0d", v.incr), nt, expT);
  endtask

  task automatic sampleRun(input logic as);
    logic prevMiso, prevPrev, lastSample;
    @(negedge clk);
    ssActive = 0; gateOff = 1; cpol = 0; misoIn = 0;
    loadProf(0, 12'd2048, 1'b0, 1'b0, 1'b1, as);
    repeat (3) @(negedge clk);
    startCmd(0);
    prevMiso = misoIn; prevPrev = misoIn; lastSample = sampleBit;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (latchStb)
        chk($sformatf("R9 capture async=%0d", as), int'(sampleBit), int'(as ? prevMiso : prevPrev));
      else
        chk("R9 hold between latch edges", int'(sampleBit), int'(lastSample));
      lastSample = sampleBit;
      prevPrev = prevMiso;
      misoIn = c[0];
      prevMiso = misoIn;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int tog;
    logic prev;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 sck idle in reset", int'(sck), 0);
    chk("R1 strobes in reset", int'(launchStb | latchStb), 0);
    chk("R1 sample in reset", int'(sampleBit), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 sck idle after reset", int'(sck), 0);

    for (int i = 0; i < 12; i++) runVec(VECS[i]);

    // R8 gating: held idle, then free running without strobes
    @(negedge clk);
    ssActive = 0; gateOff = 1; cpol = 0;
    loadProf(0, 12'd1024, 1'b0, 1'b1, 1'b1, 1'b0);
    cmdStart = 1; profSel = 0;
    @(negedge clk);
    cmdStart = 0;
    tog = 0; prev = sck;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sck != prev) tog++;
      prev = sck;
    end
    chk("R8 gated clock stays idle", tog, 0);
    gateOff = 0;
    tog = 0;
    begin
      int ns = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sck != prev) tog++;
        if (launchStb || latchStb) ns++;
        prev = sck;
      end
      chk("R8 ungated clock runs", tog, 10);
      chk("R7 R8 no strobes without ssActive", ns, 0);
    end
    gateOff = 1;
    @(negedge clk);
    chk("R8 gate returns sck to idle", int'(sck), 0);

    // R5 restart in mid run
    loadProf(1, 12'd700, 1'b1, 1'b1, 1'b0, 1'b0);
    cpol = 1;
    startCmd(1);
    repeat (10) @(negedge clk);
    cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    chk("R5 restart clears phase", int'(sck), 1);
    begin
      int first = 0;
      prev = sck;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (sck != prev && first == 0) first = k;
        prev = sck;
      end
      chk("R5 first edge after restart", first, 3);
    end

    // R9 input capture paths
    sampleRun(1'b1);
    sampleRun(1'b0);

    finishRun();
  end
endmodule